// File: doc/BRIEF.md
# Sequenced Colour Palette Loader

This block holds a 256-entry colour lookup table with an 8-bit red, green and blue part in each entry. Software fills it through a 16-byte register window that takes 32-bit writes. One register selects the entry to load. A second register receives the three colour parts one after another: red first, then green, then blue. In each case the value is taken from the top byte of the bus word.

A small sequencer tracks which colour part comes next. After the blue part it steps to the next entry by itself, so a whole palette can be streamed as one run of data writes. A scan-out engine reads the table through a separate read port that never competes with the write side.

After reset the block runs a sweep that initialises the table, one entry per cycle. It holds off the write stream until the sweep has finished. The write interface is valid/ready. A transfer happens on a rising edge where both `wr_valid` and `wr_ready` are high. While `wr_valid` is high and `wr_ready` is low, the master must keep the address, strobe and data steady. `wr_ready` is low only while the initialisation sweep runs. Bus reads take a one-cycle pulse and are answered on the following cycle.

Top module: `pal_dac_port`

## Requirements
- R1: An accepted full-word write to byte offset 0x0 loads the entry pointer from bits 31:24 of `wr_data` and sets the colour sequencer back to red.
- R2: An accepted full-word write to byte offset 0x4 stores bits 31:24 into the colour part that the sequencer selects at the entry pointer. Code 0 selects red, code 1 green and code 2 blue. Bits 23:0 have no effect.
- R3: After a red store the sequencer moves to green. After a green store it moves to blue. The entry pointer does not change in either case.
- R4: After a blue store the entry pointer increments modulo 256 (255 wraps to 0) and the sequencer returns to red.
- R5: Accepted writes to byte offsets 0x8 and 0xC change neither the table, nor the pointer, nor the sequencer.
- R6: A one-cycle `rd_en` pulse gives `rd_ack` high on the following cycle with `rd_data` equal to 0, whatever has been written.
- R7: After reset, entries 0 to 254 read as black (0x000000) and entry 255 reads as white (0xFFFFFF). The pointer is 0 and the sequencer is at red.
- R8: After reset is released, `init_busy` stays high for exactly 256 cycles. During that time `wr_ready` is low. A write held valid in that period is accepted after the sweep and is not lost.
- R9: Only full-word writes take effect. A write with `wr_strb` other than 4'hF, or with `wr_addr[1:0]` non-zero, changes no state.
- R10: `disp_rgb` is {red, green, blue} (red in bits 23:16) of entry `disp_idx`, as the table stood before the previous rising edge. A store accepted at edge E first shows at `disp_rgb` after edge E+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted (low during initialisation) |
| wr_addr | input | 4 | Byte offset within the register window |
| wr_strb | input | 4 | Byte-lane strobes of the write |
| wr_data | input | 32 | Write data; the register value is in bits 31:24 |
| rd_en | input | 1 | One-cycle register read request |
| rd_ack | output | 1 | Read answer valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data, always zero |
| disp_idx | input | 8 | Entry selected by the scan-out side |
| disp_rgb | output | 24 | Registered colour of the selected entry |
| init_busy | output | 1 | Initialisation sweep in progress |

## Verification
A sequencer that is out of step shows up at once: the next data write lands in the wrong colour part or the wrong entry, and the display port shows it two edges after the write is accepted. A pointer that fails to wrap or to reload shows up in the same way on the first store that follows. A sweep that stops early or runs long leaves entry 255 wrong or shifts the edge where `wr_ready` rises. The bench therefore counts the busy cycles and reads back the two ends of the table. Writes that should be ignored are followed straight away by a real store, so any state they disturbed becomes visible through that store.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // colour part selector; the code order is the loading order
  typedef enum logic [1:0] {
    CS_RED = 2'd0,
    CS_GRN = 2'd1,
    CS_BLU = 2'd2
  } comp_sel_e;

  localparam int NCOMP = 3;
endpackage

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc,
  input  logic [AW-1:0]              addr,
  input  logic [DW/8-1:0]            strb,
  input  logic [DW-1:0]              data,
  output logic [pal_pkg::NCOMP-1:0]  comp_we,
  output logic [IDX_W-1:0]           ptr,
  output logic [COMP_W-1:0]          comp_val
);
  import pal_pkg::*;

  localparam int WORD_LSB = $clog2(DW/8);

  comp_sel_e        sel_q;
  logic [IDX_W-1:0] ptr_q;
  logic             full_word;
  logic             hit_ptr;
  logic             hit_dat;
  logic [AW-WORD_LSB-1:0] word_off;

  assign word_off  = addr[AW-1:WORD_LSB];
  assign full_word = (strb == '1) && (addr[WORD_LSB-1:0] == '0);
  assign hit_ptr   = acc && full_word && (word_off == 0);
  assign hit_dat   = acc && full_word && (word_off == 1);
  assign comp_val  = data[DW-1 -: COMP_W];
  assign ptr       = ptr_q;

  always_comb begin
    comp_we = '0;
    if (hit_dat) begin
      case (sel_q)
        CS_RED:  comp_we = 3'b001;
        CS_GRN:  comp_we = 3'b010;
        CS_BLU:  comp_we = 3'b100;
        default: comp_we = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sel_q <= CS_RED;
    end else if (hit_ptr) begin
      ptr_q <= data[DW-1 -: IDX_W];
      sel_q <= CS_RED;
    end else if (hit_dat) begin
      case (sel_q)
        CS_RED: sel_q <= CS_GRN;
        CS_GRN: sel_q <= CS_BLU;
        CS_BLU: begin
          ptr_q <= ptr_q + 1'b1;
          sel_q <= CS_RED;
        end
        default: sel_q <= CS_RED;
      endcase
    end
  end

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ptr |=> (ptr_q == $past(data[DW-1 -: IDX_W])) && (sel_q == CS_RED));

  assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dat && sel_q == CS_RED) |=> (sel_q == CS_GRN) && $stable(ptr_q));

  assert_blue_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dat && sel_q == CS_BLU) |=>
      (ptr_q == IDX_W'($past(ptr_q) + 1)) && (sel_q == CS_RED));

  assert_ignored_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit_ptr && !hit_dat) |=> $stable(ptr_q) && $stable(sel_q));

  assert_one_part_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != 2'd3);
endmodule

// File: rtl/pal_init.sv
module pal_init #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         busy,
  output logic [IDX_W-1:0]             init_idx,
  output logic [3*COMP_W-1:0]          init_val
);
  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;
  logic             last;

  assign last     = (cnt_q == '1);
  assign busy     = busy_q;
  assign init_idx = cnt_q;
  assign init_val = last ? '1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assert_sweep_ends_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '1));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !busy_q);
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [pal_pkg::NCOMP-1:0]   we,
  input  logic [IDX_W-1:0]            widx,
  input  logic [3*COMP_W-1:0]         wval,
  input  logic [IDX_W-1:0]            ridx,
  output logic [3*COMP_W-1:0]         rval
);
  localparam int ENTRIES = 1 << IDX_W;

  for (genvar c = 0; c < pal_pkg::NCOMP; c++) begin : g_part
    localparam int LSB = (pal_pkg::NCOMP - 1 - c) * COMP_W;
    logic [COMP_W-1:0] mem [ENTRIES];
    logic [COMP_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[c]) mem[widx] <= wval[LSB +: COMP_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= mem[ridx];
    end

    assign rval[LSB +: COMP_W] = rd_q;
  end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW/8-1:0]     wr_strb,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  output logic                rd_ack,
  output logic [DW-1:0]       rd_data,
  input  logic [IDX_W-1:0]    disp_idx,
  output logic [3*COMP_W-1:0] disp_rgb,
  output logic                init_busy
);
  localparam int NC = pal_pkg::NCOMP;

  logic              busy;
  logic [IDX_W-1:0]  i_idx;
  logic [3*COMP_W-1:0] i_val;
  logic [NC-1:0]     s_we;
  logic [IDX_W-1:0]  s_ptr;
  logic [COMP_W-1:0] s_val;
  logic [NC-1:0]     t_we;
  logic [IDX_W-1:0]  t_idx;
  logic [3*COMP_W-1:0] t_val;
  logic              acc;
  logic              ack_q;

  assign wr_ready  = !busy;
  assign init_busy = busy;
  assign acc       = wr_valid && wr_ready;

  pal_init #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_init (
    .clk(clk), .rst_n(rst_n), .busy(busy), .init_idx(i_idx), .init_val(i_val)
  );

  pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .addr(wr_addr), .strb(wr_strb),
    .data(wr_data), .comp_we(s_we), .ptr(s_ptr), .comp_val(s_val)
  );

  // the sweep owns the table while it runs; the sequencer cannot fire then
  always_comb begin
    if (busy) begin
      t_we  = '1;
      t_idx = i_idx;
      t_val = i_val;
    end else begin
      t_we  = s_we;
      t_idx = s_ptr;
      t_val = {NC{s_val}};
    end
  end

  pal_table #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(t_we), .widx(t_idx), .wval(t_val),
    .ridx(disp_idx), .rval(disp_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= rd_en;
  end

  assign rd_ack  = ack_q;
  assign rd_data = '0;

  assert_read_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack);

  assert_no_stray_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_ack);

  assert_seq_quiet_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (s_we == '0));
endmodule

// File: tb/pal_dac_port_test.sv
module pal_dac_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [3:0]  wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic [7:0]  disp_idx = '0;
  logic [23:0] disp_rgb;
  logic        init_busy;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] m_ptr;
  int         m_sel;

  always #10 clk = ~clk;

  pal_dac_port uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
    .rd_en(rd_en), .rd_ack(rd_ack), .rd_data(rd_data),
    .disp_idx(disp_idx), .disp_rgb(disp_rgb), .init_busy(init_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      mr[i] = 8'h00; mg[i] = 8'h00; mb[i] = 8'h00;
    end
    mr[255] = 8'hFF; mg[255] = 8'hFF; mb[255] = 8'hFF;
    m_ptr = 8'h00;
    m_sel = 0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
    if (s == 4'hF && a[1:0] == 2'b00) begin
      if (a[3:2] == 2'd0) begin
        m_ptr = d[31:24]; m_sel = 0;
      end else if (a[3:2] == 2'd1) begin
        case (m_sel)
          0: begin mr[m_ptr] = d[31:24]; m_sel = 1; end
          1: begin mg[m_ptr] = d[31:24]; m_sel = 2; end
          default: begin mb[m_ptr] = d[31:24]; m_ptr = m_ptr + 8'd1; m_sel = 0; end
        endcase
      end
    end
  endtask

  // returns at the negedge just after the accepting rising edge
  task automatic bus_write(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(a, s, d);
  endtask

  task automatic wr_ptr(input logic [7:0] v);
    bus_write(4'h0, 4'hF, {v, 24'h000000});
  endtask

  task automatic wr_part(input logic [7:0] v);
    bus_write(4'h4, 4'hF, {v, 24'h5A3C81});
  endtask

  task automatic peek(input logic [7:0] idx, output logic [23:0] v);
    @(negedge clk);
    disp_idx = idx;
    @(negedge clk);
    v = disp_rgb;
  endtask

  task automatic chk_entry(input string req, input logic [7:0] idx, input logic [23:0] exp);
    logic [23:0] v;
    peek(idx, v);
    chk(req, {8'h00, v}, {8'h00, exp});
    chk({req, " model"}, {8'h00, v}, {8'h00, mr[idx], mg[idx], mb[idx]});
  endtask

  task automatic do_reset(output int busy_cycles);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    busy_cycles = 0;
    while (init_busy && busy_cycles < 1000) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int n;
    do_reset(n);
    chk("R8 busy cycles", n, 256);
    chk("R8 ready after sweep", {31'd0, wr_ready}, 1);
    chk_entry("R7 entry 0 black", 8'd0, 24'h000000);
    chk_entry("R7 entry 77 black", 8'd77, 24'h000000);
    chk_entry("R7 entry 254 black", 8'd254, 24'h000000);
    chk_entry("R7 entry 255 white", 8'd255, 24'hFFFFFF);
    wr_part(8'hAB);
    chk_entry("R7 pointer 0 and red after reset", 8'd0, 24'hAB0000);
  endtask

  task automatic t_stream();
    wr_ptr(8'h0A);
    wr_part(8'h11); wr_part(8'h22); wr_part(8'h33);
    wr_part(8'h44); wr_part(8'h55); wr_part(8'h66);
    chk_entry("R2 R3 entry 10", 8'h0A, 24'h112233);
    chk_entry("R4 auto step entry 11", 8'h0B, 24'h445566);
    chk_entry("R4 entry 12 untouched", 8'h0C, 24'h000000);
  endtask

  task automatic t_reload();
    wr_ptr(8'h14); wr_part(8'h77);
    wr_ptr(8'h1E); wr_part(8'h99);
    chk_entry("R1 reload restarts at red", 8'h1E, 24'h990000);
    chk_entry("R1 partial entry kept", 8'h14, 24'h770000);
  endtask

  task automatic t_wrap();
    wr_ptr(8'hFF);
    wr_part(8'h01); wr_part(8'h02); wr_part(8'h03);
    chk_entry("R4 entry 255 loaded", 8'hFF, 24'h010203);
    wr_part(8'hC0);
    chk_entry("R4 wrap to entry 0", 8'h00, 24'hC00000);
  endtask

  task automatic t_ignore();
    wr_ptr(8'h40); wr_part(8'h10);
    bus_write(4'h8, 4'hF, 32'hEE000000);
    bus_write(4'hC, 4'hF, 32'h00000000);
    chk_entry("R5 offsets 8 and C ignored", 8'h40, 24'h100000);
    bus_write(4'h4, 4'h8, 32'hDD000000);
    bus_write(4'h5, 4'hF, 32'hCC000000);
    bus_write(4'h0, 4'h7, 32'h50000000);
    chk_entry("R9 partial writes ignored", 8'h40, 24'h100000);
    wr_part(8'h20); wr_part(8'h30);
    chk_entry("R5 R9 sequence undisturbed", 8'h40, 24'h102030);
    wr_part(8'h41);
    chk_entry("R9 pointer not reloaded", 8'h41, 24'h410000);
  endtask

  task automatic t_latency();
    @(negedge clk);
    disp_idx = 8'h80;
    wr_ptr(8'h80); wr_part(8'h5A); wr_part(8'h5B);
    wr_part(8'h5C);
    chk("R10 old value after edge E", {8'h00, disp_rgb}, 32'h005A5B00);
    @(negedge clk);
    chk("R10 new value after edge E+1", {8'h00, disp_rgb}, 32'h005A5B5C);
  endtask

  task automatic t_hold();
    @(negedge clk);
    rst_n = 1'b0;
    wr_valid = 1'b1; wr_addr = 4'h4; wr_strb = 4'hF; wr_data = 32'h3C000000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (5) @(negedge clk);
    chk("R8 ready low in sweep", {31'd0, wr_ready}, 0);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(4'h4, 4'hF, 32'h3C000000);
    chk_entry("R8 held write lands after sweep", 8'h00, 24'h3C0000);
    chk_entry("R8 sweep still whitens 255", 8'hFF, 24'hFFFFFF);
  endtask

  task automatic t_read();
    @(negedge clk);
    chk("R6 no ack idle", {31'd0, rd_ack}, 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 ack", {31'd0, rd_ack}, 1);
    chk("R6 data zero", rd_data, 32'h0);
    @(negedge clk);
    chk("R6 single ack", {31'd0, rd_ack}, 0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_reload();
    t_wrap();
    t_ignore();
    t_latency();
    t_read();
    t_hold();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule